// File: doc/BRIEF.md
# CDS Oversampling Conversion Sequencer

This block is the digital back end of an integrating charge converter. A synchronous start pulse opens a conversion. Each conversion runs a number of integrations, and each integration has four phases: a one-clock reset phase, an acquisition window whose length comes from a two-bit acquisition code, an optional initial data point, and a final data point. Each data point averages M raw samples from the converter sample stream. Only cycles where the sample strobe is high count as samples.

When correlated double sampling is enabled, every integration contributes its final average minus its initial average. When it is disabled, only the final average counts. The contributions of L integrations are summed. The sum is then clamped to the code range of the selected output format, either 21-bit two's complement or 20-bit straight binary, in unipolar or bipolar range. It is presented as a result word with a one-clock valid pulse.

The configuration fields are checked when the start pulse arrives. An illegal configuration produces a one-clock error pulse and no result. A legal configuration is latched, so later changes to the fields have no effect on the conversion in progress.

Top module: `cds_conv_seq`

## Requirements
- R1: At start the configuration is legal only if the log2 of M (`cfg_m_log2`) is at most 8, L is at least 1, and L times M is at most 256. An illegal start drives `res_err` high for the single cycle after the start edge, aborts any running conversion, and produces no `res_valid`.
- R2: The combination of bipolar range, straight binary format and CDS enabled (acquisition code not 00) is illegal and is rejected as in R1.
- R3: Each integration ignores the sample stream for 1 reset clock plus an acquisition window. The window is 0 clocks for codes 00 and 01, 15 clocks for code 10 and 31 clocks for code 11. It then accepts M strobed samples as the initial point (codes 01, 10 and 11 only), then M strobed samples as the final point.
- R4: A point's average is the sum of its M samples shifted right arithmetically by log2(M), which rounds toward negative infinity.
- R5: With CDS enabled (code not 00), an integration contributes final average minus initial average. With code 00 it contributes the final average only.
- R6: The contributions of L integrations are summed into one value v.
- R7: Unipolar two's complement: the result is v clamped to [-4096, 2^20-1], as a 21-bit two's complement word (minimum code 0x1FF000).
- R8: Unipolar straight binary: the result is v+4096 clamped to [0, 2^20-1], placed in bits 19:0 with bit 20 zero. Zero input gives 0x01000.
- R9: Bipolar two's complement: v is clamped to [-2^19-4096, 2^19-1]. With CDS the result is that value. Without CDS it is that value plus 2^19, so zero gives 0x080000.
- R10: Bipolar straight binary (CDS off): the result is v+2^19 clamped to [0, 2^20-1]. Zero gives 0x80000, and the extremes are all ones and all zeros.
- R11: `res_valid` is high for exactly the one cycle after the clock edge that accepts the last final-point sample of the L-th integration. `res_data` changes only with `res_valid` and then holds.
- R12: A start pulse restarts the sequence from the reset phase at any time, abandoning a conversion in progress. Configuration inputs changed after the start edge have no effect.
- R13: After reset, `res_data`, `res_valid` and `res_err` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Starts (or restarts) a conversion, latching the configuration |
| cfg_k | input | 2 | Acquisition-time code, also enables CDS when not 00 |
| cfg_m_log2 | input | 4 | log2 of the oversampling count M |
| cfg_l | input | L_W (9) | Integrations per conversion L |
| cfg_straight | input | 1 | 1 = straight binary, 0 = two's complement |
| cfg_bipolar | input | 1 | 1 = bipolar range, 0 = unipolar |
| smp_valid | input | 1 | Raw sample strobe |
| smp_data | input | SMP_W (20) | Raw signed converter sample |
| res_data | output | OUT_W+1 (21) | Formatted result word |
| res_valid | output | 1 | One-cycle result strobe |
| res_err | output | 1 | One-cycle illegal-configuration strobe |

## Verification
The bound checker watches four properties on every cycle:
- the valid pulse lasts one cycle and the result word never moves without it;
- error pulses occur only right after a start and never together with a result;
- a start always suppresses a result in the following cycle;
- a straight-binary result never sets its top bit, and no result is ever produced under the overflowing bipolar straight-binary CDS setting.

Only the directed scenarios can show the rest:
- the arithmetic: floor averaging, the CDS difference, the L-fold sum and each clamp boundary;
- the exact sample windows skipped for each acquisition code;
- the latching of the configuration across mid-conversion changes and restarts.

// File: rtl/cds_conv_pkg.sv
package cds_conv_pkg;

   localparam int M_LOG2_MAX = 8;
   localparam int LM_LIMIT   = 256;
   localparam int ACQ_W      = 5;

   typedef enum logic [2:0] {
      PH_IDLE,
      PH_RST,
      PH_ACQ,
      PH_INIT,
      PH_FIN
   } phase_t;

   typedef struct packed {
      logic [1:0] k;
      logic [3:0] m_log2;
      logic       straight;
      logic       bipolar;
   } mode_t;

   // acquisition window length for each acquisition code
   function automatic logic [ACQ_W-1:0] acq_clocks(input logic [1:0] k);
      case (k)
         2'b10:   return ACQ_W'(15);
         2'b11:   return ACQ_W'(31);
         default: return '0;
      endcase
   endfunction

   function automatic logic cds_on(input logic [1:0] k);
      return k != 2'b00;
   endfunction

endpackage

// File: rtl/cds_cfg_check.sv
module cds_cfg_check
   import cds_conv_pkg::*;
#(
   parameter int L_W = 9
) (
   input  mode_t          mode,
   input  logic [L_W-1:0] l_num,
   output logic           legal
);

   localparam int PROD_W = L_W + 16;

   logic [PROD_W-1:0] lm_prod;
   logic              m_ok;
   logic              l_ok;
   logic              lm_ok;
   logic              fmt_ok;

   always_comb begin
      lm_prod = PROD_W'(l_num) << mode.m_log2;
      m_ok    = mode.m_log2 <= 4'(M_LOG2_MAX);
      l_ok    = l_num != '0;
      lm_ok   = lm_prod <= PROD_W'(LM_LIMIT);
      fmt_ok  = !(mode.bipolar && mode.straight && cds_on(mode.k));
      legal   = m_ok && l_ok && lm_ok && fmt_ok;
   end

endmodule

// File: rtl/cds_phase_ctl.sv
module cds_phase_ctl
   import cds_conv_pkg::*;
#(
   parameter int L_W = 9
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             go,
   input  logic             abort,
   input  logic             cds,
   input  logic [ACQ_W-1:0] acq_len,
   input  logic [3:0]       m_log2,
   input  logic [L_W-1:0]   l_num,
   input  logic             smp_valid,
   output logic             take_init,
   output logic             take_fin,
   output logic             fin_last,
   output logic             conv_last
);

   localparam int CNT_W = M_LOG2_MAX + 1;

   phase_t           phase;
   logic [CNT_W-1:0] smp_cnt;
   logic [CNT_W-1:0] m_top;
   logic [ACQ_W-1:0] acq_cnt;
   logic [L_W-1:0]   integ_cnt;
   logic             quiet;
   logic             pt_full;
   phase_t           after_acq;

   always_comb begin
      m_top     = (CNT_W'(1) << m_log2) - CNT_W'(1);
      quiet     = !go && !abort;
      pt_full   = smp_cnt == m_top;
      after_acq = cds ? PH_INIT : PH_FIN;
      take_init = quiet && (phase == PH_INIT) && smp_valid;
      take_fin  = quiet && (phase == PH_FIN) && smp_valid;
      fin_last  = take_fin && pt_full;
      conv_last = fin_last && (integ_cnt == l_num - L_W'(1));
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase     <= PH_IDLE;
         smp_cnt   <= '0;
         acq_cnt   <= '0;
         integ_cnt <= '0;
      end else if (go) begin
         phase     <= PH_RST;
         smp_cnt   <= '0;
         acq_cnt   <= '0;
         integ_cnt <= '0;
      end else if (abort) begin
         phase     <= PH_IDLE;
      end else begin
         case (phase)
            PH_RST: begin
               acq_cnt <= '0;
               phase   <= (acq_len != '0) ? PH_ACQ : after_acq;
            end
            PH_ACQ: begin
               if (acq_cnt == acq_len - ACQ_W'(1)) begin
                  phase <= after_acq;
               end else begin
                  acq_cnt <= acq_cnt + ACQ_W'(1);
               end
            end
            PH_INIT: begin
               if (take_init) begin
                  if (pt_full) begin
                     smp_cnt <= '0;
                     phase   <= PH_FIN;
                  end else begin
                     smp_cnt <= smp_cnt + CNT_W'(1);
                  end
               end
            end
            PH_FIN: begin
               if (take_fin) begin
                  if (pt_full) begin
                     smp_cnt <= '0;
                     if (conv_last) begin
                        phase <= PH_IDLE;
                     end else begin
                        integ_cnt <= integ_cnt + L_W'(1);
                        phase     <= PH_RST;
                     end
                  end else begin
                     smp_cnt <= smp_cnt + CNT_W'(1);
                  end
               end
            end
            default: phase <= PH_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/cds_point_acc.sv
module cds_point_acc
   import cds_conv_pkg::*;
#(
   parameter int SMP_W = 20,
   parameter int L_W   = 9,
   parameter int ACC_W = SMP_W + 1 + L_W
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    clr,
   input  logic                    take_init,
   input  logic                    take_fin,
   input  logic                    fin_last,
   input  logic                    cds,
   input  logic [3:0]              m_log2,
   input  logic signed [SMP_W-1:0] smp,
   output logic signed [ACC_W-1:0] acc_next
);

   localparam int SUM_W  = SMP_W + M_LOG2_MAX;
   localparam int DIFF_W = SMP_W + 1;

   logic signed [SUM_W-1:0]  sum_init;
   logic signed [SUM_W-1:0]  sum_fin;
   logic signed [SUM_W-1:0]  smp_ext;
   logic signed [SUM_W-1:0]  fin_total;
   logic signed [SUM_W-1:0]  fin_shr;
   logic signed [SUM_W-1:0]  init_shr;
   logic signed [DIFF_W-1:0] fin_avg;
   logic signed [DIFF_W-1:0] init_avg;
   logic signed [DIFF_W-1:0] delta;
   logic signed [ACC_W-1:0]  acc;

   always_comb begin
      smp_ext   = {{(SUM_W-SMP_W){smp[SMP_W-1]}}, smp};
      fin_total = sum_fin + smp_ext;
      fin_shr   = fin_total >>> m_log2;
      init_shr  = sum_init >>> m_log2;
      fin_avg   = DIFF_W'(fin_shr);
      init_avg  = DIFF_W'(init_shr);
      delta     = cds ? (fin_avg - init_avg) : fin_avg;
      acc_next  = acc + ACC_W'(delta);
   end

   always_ff @(posedge clk) begin
      if (!rst_n || clr) begin
         sum_init <= '0;
         sum_fin  <= '0;
         acc      <= '0;
      end else begin
         if (take_init) begin
            sum_init <= sum_init + smp_ext;
         end
         if (fin_last) begin
            sum_init <= '0;
            sum_fin  <= '0;
            acc      <= acc_next;
         end else if (take_fin) begin
            sum_fin  <= fin_total;
         end
      end
   end

endmodule

// File: rtl/cds_out_fmt.sv
module cds_out_fmt #(
   parameter int ACC_W    = 30,
   parameter int OUT_W    = 20,
   parameter bit SATURATE = 1'b1
) (
   input  logic signed [ACC_W-1:0] v,
   input  logic                    straight,
   input  logic                    bipolar,
   input  logic                    cds,
   output logic [OUT_W:0]          code
);

   localparam longint HEAD_L = longint'(1) << (OUT_W - 8);
   localparam longint HALF_L = longint'(1) << (OUT_W - 1);
   localparam longint FULL_L = longint'(1) << OUT_W;
   localparam logic signed [ACC_W-1:0] HEAD = ACC_W'(HEAD_L);
   localparam logic signed [ACC_W-1:0] HALF = ACC_W'(HALF_L);
   localparam logic signed [ACC_W-1:0] FULL = ACC_W'(FULL_L);
   localparam logic signed [ACC_W-1:0] ONE  = ACC_W'(1);

   logic signed [ACC_W-1:0] lo;
   logic signed [ACC_W-1:0] hi;
   logic signed [ACC_W-1:0] off;
   logic signed [ACC_W-1:0] clamped;
   logic signed [ACC_W-1:0] shifted;

   always_comb begin
      case ({bipolar, straight})
         2'b00: begin lo = -HEAD;        hi = FULL - ONE;        off = '0;   end
         2'b01: begin lo = -HEAD;        hi = FULL - ONE - HEAD; off = HEAD; end
         2'b10: begin lo = -HALF - HEAD; hi = HALF - ONE;        off = cds ? '0 : HALF; end
         default: begin lo = -HALF;      hi = HALF - ONE;        off = HALF; end
      endcase
   end

   generate
      if (SATURATE) begin : g_sat
         always_comb begin
            if (v < lo)      clamped = lo;
            else if (v > hi) clamped = hi;
            else             clamped = v;
         end
      end else begin : g_wrap
         always_comb clamped = v;
      end
   endgenerate

   always_comb begin
      shifted = clamped + off;
      code    = shifted[OUT_W:0];
   end

endmodule

// File: rtl/cds_conv_seq.sv
module cds_conv_seq
   import cds_conv_pkg::*;
#(
   parameter int SMP_W = 20,
   parameter int OUT_W = 20,
   parameter int L_W   = 9
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [1:0]       cfg_k,
   input  logic [3:0]       cfg_m_log2,
   input  logic [L_W-1:0]   cfg_l,
   input  logic             cfg_straight,
   input  logic             cfg_bipolar,
   input  logic             smp_valid,
   input  logic [SMP_W-1:0] smp_data,
   output logic [OUT_W:0]   res_data,
   output logic             res_valid,
   output logic             res_err
);

   localparam int ACC_W = SMP_W + 1 + L_W;

   generate
      if (L_W < 9) begin : g_bad_lw
         $error("L_W must hold an L of 256");
      end
      if (OUT_W < 9) begin : g_bad_ow
         $error("OUT_W too small for the headroom code");
      end
      if (SMP_W > OUT_W) begin : g_bad_sw
         $error("SMP_W must not exceed OUT_W");
      end
   endgenerate

   mode_t                   mode_in;
   mode_t                   lat;
   logic [L_W-1:0]          lat_l;
   logic                    legal;
   logic                    go;
   logic                    abort;
   logic                    lat_cds;
   logic                    lat_straight;
   logic                    lat_bipolar;
   logic                    take_init;
   logic                    take_fin;
   logic                    fin_last;
   logic                    conv_last;
   logic signed [ACC_W-1:0] acc_next;
   logic [OUT_W:0]          fmt_code;

   always_comb begin
      mode_in.k        = cfg_k;
      mode_in.m_log2   = cfg_m_log2;
      mode_in.straight = cfg_straight;
      mode_in.bipolar  = cfg_bipolar;
      go               = start && legal;
      abort            = start && !legal;
      lat_cds          = cds_on(lat.k);
      lat_straight     = lat.straight;
      lat_bipolar      = lat.bipolar;
   end

   cds_cfg_check #(.L_W(L_W)) u_check (
      .mode  (mode_in),
      .l_num (cfg_l),
      .legal (legal)
   );

   cds_phase_ctl #(.L_W(L_W)) u_phase (
      .clk       (clk),
      .rst_n     (rst_n),
      .go        (go),
      .abort     (abort),
      .cds       (lat_cds),
      .acq_len   (acq_clocks(lat.k)),
      .m_log2    (lat.m_log2),
      .l_num     (lat_l),
      .smp_valid (smp_valid),
      .take_init (take_init),
      .take_fin  (take_fin),
      .fin_last  (fin_last),
      .conv_last (conv_last)
   );

   cds_point_acc #(.SMP_W(SMP_W), .L_W(L_W), .ACC_W(ACC_W)) u_acc (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (go),
      .take_init (take_init),
      .take_fin  (take_fin),
      .fin_last  (fin_last),
      .cds       (lat_cds),
      .m_log2    (lat.m_log2),
      .smp       (smp_data),
      .acc_next  (acc_next)
   );

   cds_out_fmt #(.ACC_W(ACC_W), .OUT_W(OUT_W), .SATURATE(1'b1)) u_fmt (
      .v        (acc_next),
      .straight (lat.straight),
      .bipolar  (lat.bipolar),
      .cds      (lat_cds),
      .code     (fmt_code)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lat       <= '0;
         lat_l     <= L_W'(1);
         res_data  <= '0;
         res_valid <= 1'b0;
         res_err   <= 1'b0;
      end else begin
         if (go) begin
            lat   <= mode_in;
            lat_l <= cfg_l;
         end
         res_valid <= conv_last;
         res_err   <= abort;
         if (conv_last) begin
            res_data <= fmt_code;
         end
      end
   end

endmodule

// File: rtl/cds_conv_chk.sv
module cds_conv_chk #(
   parameter int OUT_W = 20
) (
   input logic           clk,
   input logic           rst_n,
   input logic           start,
   input logic           res_valid,
   input logic           res_err,
   input logic [OUT_W:0] res_data,
   input logic           lat_straight,
   input logic           lat_bipolar,
   input logic           lat_cds
);

   AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |=> !res_valid); // R11

   AST_DATA_ONLY_WITH_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(res_data) |-> res_valid); // R11

   AST_ERR_FOLLOWS_START: assert property (@(posedge clk) disable iff (!rst_n)
      res_err |-> $past(start)); // R1

   AST_ERR_NO_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
      res_err |-> !res_valid); // R1

   AST_START_NO_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
      $past(start) |-> !res_valid); // R12

   AST_SB_TOP_BIT: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && lat_straight) |-> !res_data[OUT_W]); // R8

   AST_NO_SB_BIPOLAR_CDS: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |-> !(lat_straight && lat_bipolar && lat_cds)); // R2

endmodule

bind cds_conv_seq cds_conv_chk #(.OUT_W(OUT_W)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .start        (start),
   .res_valid    (res_valid),
   .res_err      (res_err),
   .res_data     (res_data),
   .lat_straight (lat_straight),
   .lat_bipolar  (lat_bipolar),
   .lat_cds      (lat_cds)
);

// File: tb/tb_cds_conv_seq.sv
module tb_cds_conv_seq;

   localparam int SMP_W = 20;
   localparam int OUT_W = 20;
   localparam int L_W   = 9;

   logic             clk = 1'b0;
   logic             rst_n;
   logic             start;
   logic [1:0]       cfg_k;
   logic [3:0]       cfg_m_log2;
   logic [L_W-1:0]   cfg_l;
   logic             cfg_straight;
   logic             cfg_bipolar;
   logic             smp_valid;
   logic [SMP_W-1:0] smp_data;
   logic [OUT_W:0]   res_data;
   logic             res_valid;
   logic             res_err;

   int n_tests = 0;
   int n_fail  = 0;

   always #10 clk = ~clk;

   cds_conv_seq #(.SMP_W(SMP_W), .OUT_W(OUT_W), .L_W(L_W)) dut (
      .clk          (clk),
      .rst_n        (rst_n),
      .start        (start),
      .cfg_k        (cfg_k),
      .cfg_m_log2   (cfg_m_log2),
      .cfg_l        (cfg_l),
      .cfg_straight (cfg_straight),
      .cfg_bipolar  (cfg_bipolar),
      .smp_valid    (smp_valid),
      .smp_data     (smp_data),
      .res_data     (res_data),
      .res_valid    (res_valid),
      .res_err      (res_err)
   );

   task automatic check(input bit ok, input string tag, input string what,
                        input longint act, input longint exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
      end
   endtask

   function automatic longint data_at(longint base, longint step, longint n);
      return base + step * n;
   endfunction

   // expected code from the format rules R7..R10
   function automatic longint exp_code(longint v, bit straight, bit bip, bit cds);
      longint head = 4096;
      longint half = longint'(1) << 19;
      longint full = longint'(1) << 20;
      longint lo, hi, off, c;
      if (!bip && !straight)     begin lo = -head;        hi = full - 1;        off = 0;    end
      else if (!bip && straight) begin lo = -head;        hi = full - 1 - head; off = head; end
      else if (bip && !straight) begin lo = -half - head; hi = half - 1;        off = cds ? 0 : half; end
      else                       begin lo = -half;        hi = half - 1;        off = half; end
      c = (v < lo) ? lo : ((v > hi) ? hi : v);
      c = c + off;
      return c & ((longint'(1) << 21) - 1);
   endfunction

   task automatic run_conv(input string tag, input bit [1:0] k, input int ml, input int l,
                           input bit straight, input bit bip, input longint base,
                           input longint step, input bit mid_change);
      int     acq;
      bit     cds;
      longint m, pos, v, si, sf, q, expv;
      int     nvalid, nerr;
      longint seen;
      longint got;
      acq = (k == 2'b10) ? 15 : ((k == 2'b11) ? 31 : 0);
      cds = (k != 2'b00);
      m   = longint'(1) << ml;
      pos = 1;
      v   = 0;
      for (int i = 0; i < l; i++) begin
         pos += 1 + acq;
         si = 0;
         if (cds) begin
            for (longint j = 0; j < m; j++) si += data_at(base, step, pos + j);
            pos += m;
         end
         sf = 0;
         for (longint j = 0; j < m; j++) sf += data_at(base, step, pos + j);
         pos += m;
         v += (sf >>> ml) - (cds ? (si >>> ml) : 0);
      end
      q    = pos - 1;
      expv = exp_code(v, straight, bip, cds);
      nvalid = 0; nerr = 0; seen = -1; got = 0;
      @(negedge clk);
      cfg_k = k; cfg_m_log2 = 4'(ml); cfg_l = L_W'(l);
      cfg_straight = straight; cfg_bipolar = bip;
      start = 1'b1; smp_valid = 1'b1;
      smp_data = SMP_W'(data_at(base, step, 0));
      for (longint j = 0; j <= q + 3; j++) begin
         @(posedge clk);
         @(negedge clk);
         if (res_valid) begin nvalid++; seen = j; got = longint'(res_data); end
         if (res_err) nerr++;
         if (j == 0) begin
            start = 1'b0;
            if (mid_change) begin
               cfg_k = ~k; cfg_m_log2 = 4'd0; cfg_l = L_W'(1);
               cfg_straight = ~straight; cfg_bipolar = ~bip;
            end
         end
         smp_data = SMP_W'(data_at(base, step, j + 1));
      end
      smp_valid = 1'b0;
      check(nvalid == 1, tag, "result pulse count", nvalid, 1);
      check(seen == q, tag, "result cycle (R11)", seen, q);
      check(got == expv, tag, "result code", got, expv);
      check(nerr == 0, tag, "no error on legal config", nerr, 0);
      check(longint'(res_data) == expv, tag, "result held (R11)", longint'(res_data), expv);
   endtask

   task automatic run_err(input string tag, input bit [1:0] k, input int ml, input int l,
                          input bit straight, input bit bip);
      int nvalid, nerr;
      nvalid = 0; nerr = 0;
      @(negedge clk);
      cfg_k = k; cfg_m_log2 = 4'(ml); cfg_l = L_W'(l);
      cfg_straight = straight; cfg_bipolar = bip;
      start = 1'b1; smp_valid = 1'b1; smp_data = SMP_W'(100);
      @(posedge clk);
      @(negedge clk);
      start = 1'b0;
      check(res_err == 1'b1, tag, "error pulse after illegal start", res_err, 1);
      check(res_valid == 1'b0, tag, "no result with error", res_valid, 0);
      for (int j = 0; j < 60; j++) begin
         @(posedge clk);
         @(negedge clk);
         if (res_valid) nvalid++;
         if (res_err) nerr++;
      end
      smp_valid = 1'b0;
      check(nvalid == 0, tag, "no result after rejection", nvalid, 0);
      check(nerr == 0, tag, "error is one cycle", nerr, 0);
   endtask

   task automatic t_reset;
      check(res_valid == 1'b0, "R13", "res_valid after reset", res_valid, 0);
      check(res_err == 1'b0, "R13", "res_err after reset", res_err, 0);
      check(res_data == '0, "R13", "res_data after reset", longint'(res_data), 0);
   endtask

   task automatic t_restart;
      @(negedge clk);
      cfg_k = 2'b11; cfg_m_log2 = 4'd3; cfg_l = L_W'(4);
      cfg_straight = 1'b0; cfg_bipolar = 1'b0;
      start = 1'b1; smp_valid = 1'b1; smp_data = SMP_W'(7777);
      @(posedge clk);
      @(negedge clk);
      start = 1'b0;
      repeat (40) @(posedge clk);
      // R12: second start abandons the first conversion
      run_conv("R12", 2'b01, 1, 2, 1'b0, 1'b1, 20, 9, 1'b0);
   endtask

   task automatic t_gaps;
      int     seen;
      longint got, expv;
      seen = 0; got = 0;
      expv = exp_code(3000, 1'b0, 1'b1, 1'b0);
      @(negedge clk);
      cfg_k = 2'b00; cfg_m_log2 = 4'd3; cfg_l = L_W'(3);
      cfg_straight = 1'b0; cfg_bipolar = 1'b1;
      start = 1'b1; smp_valid = 1'b0; smp_data = SMP_W'(1000);
      for (int j = 0; j < 300 && seen == 0; j++) begin
         @(posedge clk);
         @(negedge clk);
         start = 1'b0;
         smp_valid = ~smp_valid;
         if (res_valid) begin seen = 1; got = longint'(res_data); end
      end
      smp_valid = 1'b0;
      // R3: only strobed samples count; R9 offset without CDS
      check(seen == 1, "R3", "result with sparse strobes", seen, 1);
      check(got == expv, "R3", "sparse strobe result", got, expv);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      rst_n = 1'b0; start = 1'b0; smp_valid = 1'b0; smp_data = '0;
      cfg_k = 2'b00; cfg_m_log2 = '0; cfg_l = L_W'(1);
      cfg_straight = 1'b0; cfg_bipolar = 1'b0;
      repeat (4) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();

      run_conv("R3",  2'b00, 0, 1, 1'b0, 1'b0, 1000, 0, 1'b0);
      run_conv("R5",  2'b10, 2, 2, 1'b0, 1'b0, -50, 7, 1'b0);
      run_conv("R6",  2'b11, 1, 3, 1'b0, 1'b1, 400, -3, 1'b0);
      run_conv("R4",  2'b01, 2, 1, 1'b0, 1'b0, -5, 1, 1'b0);
      run_conv("R4",  2'b00, 2, 1, 1'b0, 1'b0, -6, -1, 1'b0);
      run_conv("R7",  2'b00, 0, 4, 1'b0, 1'b0, 500000, 0, 1'b0);
      run_conv("R7",  2'b00, 0, 1, 1'b0, 1'b0, -10000, 0, 1'b0);
      run_conv("R8",  2'b00, 0, 1, 1'b1, 1'b0, 0, 0, 1'b0);
      run_conv("R8",  2'b01, 0, 2, 1'b1, 1'b0, 2000, 3, 1'b0);
      run_conv("R8",  2'b00, 0, 4, 1'b1, 1'b0, 500000, 0, 1'b0);
      run_conv("R8",  2'b00, 0, 1, 1'b1, 1'b0, -10000, 0, 1'b0);
      run_conv("R9",  2'b00, 0, 1, 1'b0, 1'b1, 0, 0, 1'b0);
      run_conv("R9",  2'b00, 1, 1, 1'b0, 1'b1, -100000, 0, 1'b0);
      run_conv("R9",  2'b00, 0, 2, 1'b0, 1'b1, -500000, 0, 1'b0);
      run_conv("R9",  2'b01, 0, 1, 1'b0, 1'b1, 0, 100, 1'b0);
      run_conv("R10", 2'b00, 0, 1, 1'b1, 1'b1, 0, 0, 1'b0);
      run_conv("R10", 2'b00, 0, 2, 1'b1, 1'b1, -300000, 0, 1'b0);
      run_conv("R10", 2'b00, 0, 2, 1'b1, 1'b1, 300000, 0, 1'b0);
      run_conv("R12", 2'b10, 1, 2, 1'b0, 1'b0, 77, 5, 1'b1);
      run_conv("R1",  2'b01, 8, 1, 1'b0, 1'b0, 3, 1, 1'b0);
      run_conv("R1",  2'b10, 4, 16, 1'b0, 1'b0, -300, 1, 1'b0);
      t_restart();
      t_gaps();

      run_err("R1", 2'b01, 4, 17, 1'b0, 1'b0);
      run_err("R1", 2'b00, 9, 1, 1'b0, 1'b0);
      run_err("R1", 2'b00, 0, 0, 1'b0, 1'b0);
      run_err("R2", 2'b01, 0, 1, 1'b1, 1'b1);
      run_err("R2", 2'b11, 2, 2, 1'b1, 1'b1);

      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule